// File: doc/BRIEF.md
# Deferred-Fault Register Tracker

This block is a small register file in which each entry pairs a data word with a single poison bit. It executes a simplified operation stream. Each operation names two source registers and a destination, carries a program counter, an externally computed result and a fault request, and is marked speculative or not. Arithmetic units, memory and trap handling sit outside the block. The tracker only decides what lands in the destination and whether a fault must be raised now.

A speculative operation never traps. If it faults, or if it reads a poisoned source, the destination is poisoned and its data field holds the program counter of the operation that first faulted. A later speculative consumer carries that counter forward. A non-speculative consumer, or an explicit check operation, turns the poison into a one-cycle exception report that carries the original counter. A restore operation writes data and poison together, so the pair can be saved through the read port and put back after a context switch.

Top module: `spec_tag_tracker`

## Requirements
- R1: Synchronous reset clears every register's data field and poison bit to zero and drops the exception report.
- R2: An execute operation (op_kind 2'b00) with op_spec=1, unpoisoned sources and fault_i=0 writes result_i to the destination and clears its poison bit.
- R3: An execute operation with op_spec=1, unpoisoned sources and fault_i=1 poisons the destination and writes pc_i into its data field.
- R4: An execute operation with op_spec=1 that reads a poisoned source poisons the destination and copies that source's data field into it. result_i and fault_i are then ignored.
- R5: An execute operation with op_spec=0, unpoisoned sources and fault_i=1 raises a report with exc_pc_o = its own pc_i and exc_deferred_o=0. No register is written.
- R6: An execute operation with op_spec=0 that reads a poisoned source raises a report with exc_pc_o = that source's data field and exc_deferred_o=1. No register is written.
- R7: A check operation (op_kind 2'b01) raises a report with exc_pc_o = source A's data field and exc_deferred_o=1 only if source A is poisoned. It never writes a register, and it ignores op_spec, fault_i and source B.
- R8: When both sources are poisoned, source A supplies the carried or reported counter.
- R9: A report appears on exc_valid_o for exactly one cycle, the cycle after the operation is issued. No register changes at the clock edge that raises it.
- R10: A restore operation (op_kind 2'b10) writes result_i into the destination data field and fault_i into its poison bit. The combinational read port returns both fields of the register selected by rd_idx_i.
- R11: With issue_valid_i=0, or with op_kind 2'b11, no register changes and no report is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid_i | input | 1 | Operation present this cycle |
| op_kind_i | input | 2 | 00 execute, 01 check, 10 restore, 11 no-op |
| op_spec_i | input | 1 | Operation is speculative |
| src_a_i | input | 3 | Source A register index |
| src_b_i | input | 3 | Source B register index |
| dst_i | input | 3 | Destination register index |
| pc_i | input | 16 | Program counter of the operation |
| result_i | input | 16 | Result value (restore data for restore) |
| fault_i | input | 1 | Operation faults (restore poison bit for restore) |
| rd_idx_i | input | 3 | Read port register index |
| rd_data_o | output | 16 | Data field of the selected register |
| rd_tag_o | output | 1 | Poison bit of the selected register |
| exc_valid_o | output | 1 | Exception report pulse |
| exc_pc_o | output | 16 | Counter of the faulting operation |
| exc_deferred_o | output | 1 | Report comes from a poisoned source |

## Verification
The hardest state to reach is a register whose poison was carried through two or more speculative operations and is then met by a consumer that reads a second, differently poisoned register. That is the only case where source order decides which counter surfaces. The stimulus builds it on purpose: it faults one speculative operation, chains two speculative consumers off it, restores an unrelated register with poison and a distinct counter, and then issues non-speculative, speculative and check consumers with the two poisoned registers in both source positions. Back-to-back non-speculative consumers also show that reports pulse per operation and never merge.

// File: rtl/spec_tag_pkg.sv
`timescale 1ns/1ps
package spec_tag_pkg;

    parameter int unsigned DATA_W = 16;
    parameter int unsigned REG_N  = 8;
    localparam int unsigned IDX_W = $clog2(REG_N);

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef enum logic [1:0] {
        OPK_EXEC    = 2'b00,
        OPK_CHECK   = 2'b01,
        OPK_RESTORE = 2'b10,
        OPK_NONE    = 2'b11
    } op_kind_e;

    typedef struct packed {
        op_kind_e kind;
        logic     spec;
        idx_t     src_a;
        idx_t     src_b;
        idx_t     dst;
        word_t    pc;
        word_t    result;
        logic     fault;
    } issue_t;

    typedef struct packed {
        word_t data;
        logic  tag;
    } operand_t;

    typedef struct packed {
        logic  wr_en;
        idx_t  wr_idx;
        word_t wr_data;
        logic  wr_tag;
        logic  rpt_en;
        word_t rpt_pc;
        logic  rpt_deferred;
    } outcome_t;

    // Source A has priority when both operands carry poison.
    function automatic operand_t first_poisoned(operand_t a, operand_t b);
        return a.tag ? a : b;
    endfunction

endpackage

// File: rtl/spec_tag_regfile.sv
`timescale 1ns/1ps
module spec_tag_regfile
    import spec_tag_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  idx_t     wr_idx,
    input  word_t    wr_data,
    input  logic     wr_tag,
    input  idx_t     ra_idx,
    input  idx_t     rb_idx,
    input  idx_t     rc_idx,
    output operand_t ra_o,
    output operand_t rb_o,
    output operand_t rc_o,
    output logic [REG_N-1:0] tag_vec_o,
    output word_t    data_vec_o [REG_N]
);

    word_t            data_q [REG_N];
    logic [REG_N-1:0] tag_q;

    for (genvar i = 0; i < REG_N; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                data_q[i] <= '0;
                tag_q[i]  <= 1'b0;
            end else if (wr_en && wr_idx == idx_t'(i)) begin
                data_q[i] <= wr_data;
                tag_q[i]  <= wr_tag;
            end
        end
        assign data_vec_o[i] = data_q[i];
    end

    assign tag_vec_o = tag_q;

    always_comb begin
        ra_o = '{data: data_q[ra_idx], tag: tag_q[ra_idx]};
        rb_o = '{data: data_q[rb_idx], tag: tag_q[rb_idx]};
        rc_o = '{data: data_q[rc_idx], tag: tag_q[rc_idx]};
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (tag_q == '0) && (data_q[0] == '0) && (data_q[REG_N-1] == '0));

endmodule

// File: rtl/spec_tag_resolve.sv
`timescale 1ns/1ps
module spec_tag_resolve
    import spec_tag_pkg::*;
(
    input  logic     issue_valid,
    input  issue_t   iss,
    input  operand_t opa,
    input  operand_t opb,
    output outcome_t out
);

    operand_t carried;
    logic     src_hit;

    always_comb begin
        carried = first_poisoned(opa, opb);
        src_hit = opa.tag | opb.tag;
        out     = '0;
        out.wr_idx = iss.dst;
        if (issue_valid) begin
            case (iss.kind)
                OPK_EXEC: begin
                    if (iss.spec) begin
                        out.wr_en = 1'b1;
                        if (src_hit) begin
                            out.wr_tag  = 1'b1;
                            out.wr_data = carried.data;
                        end else if (iss.fault) begin
                            out.wr_tag  = 1'b1;
                            out.wr_data = iss.pc;
                        end else begin
                            out.wr_tag  = 1'b0;
                            out.wr_data = iss.result;
                        end
                    end else begin
                        if (src_hit) begin
                            out.rpt_en       = 1'b1;
                            out.rpt_pc       = carried.data;
                            out.rpt_deferred = 1'b1;
                        end else if (iss.fault) begin
                            out.rpt_en       = 1'b1;
                            out.rpt_pc       = iss.pc;
                            out.rpt_deferred = 1'b0;
                        end else begin
                            out.wr_en   = 1'b1;
                            out.wr_tag  = 1'b0;
                            out.wr_data = iss.result;
                        end
                    end
                end
                OPK_CHECK: begin
                    if (opa.tag) begin
                        out.rpt_en       = 1'b1;
                        out.rpt_pc       = opa.data;
                        out.rpt_deferred = 1'b1;
                    end
                end
                OPK_RESTORE: begin
                    out.wr_en   = 1'b1;
                    out.wr_tag  = iss.fault;
                    out.wr_data = iss.result;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/spec_tag_report.sv
`timescale 1ns/1ps
module spec_tag_report
    import spec_tag_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rpt_en,
    input  word_t rpt_pc,
    input  logic  rpt_deferred,
    output logic  exc_valid_o,
    output word_t exc_pc_o,
    output logic  exc_deferred_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            exc_valid_o    <= 1'b0;
            exc_pc_o       <= '0;
            exc_deferred_o <= 1'b0;
        end else begin
            exc_valid_o    <= rpt_en;
            exc_pc_o       <= rpt_en ? rpt_pc : '0;
            exc_deferred_o <= rpt_en & rpt_deferred;
        end
    end

    assert_pulse_follows_request_R9: assert property (@(posedge clk) disable iff (rst)
        !rpt_en |=> !exc_valid_o);

endmodule

// File: rtl/spec_tag_tracker.sv
`timescale 1ns/1ps
module spec_tag_tracker
    import spec_tag_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      issue_valid_i,
    input  logic [1:0]                op_kind_i,
    input  logic                      op_spec_i,
    input  logic [IDX_W-1:0]          src_a_i,
    input  logic [IDX_W-1:0]          src_b_i,
    input  logic [IDX_W-1:0]          dst_i,
    input  logic [DATA_W-1:0]         pc_i,
    input  logic [DATA_W-1:0]         result_i,
    input  logic                      fault_i,
    input  logic [IDX_W-1:0]          rd_idx_i,
    output logic [DATA_W-1:0]         rd_data_o,
    output logic                      rd_tag_o,
    output logic                      exc_valid_o,
    output logic [DATA_W-1:0]         exc_pc_o,
    output logic                      exc_deferred_o
);

    issue_t           iss;
    operand_t         opa, opb, opr;
    outcome_t         res;
    logic [REG_N-1:0] tag_vec;
    word_t            data_vec [REG_N];

    always_comb begin
        iss.kind   = op_kind_e'(op_kind_i);
        iss.spec   = op_spec_i;
        iss.src_a  = src_a_i;
        iss.src_b  = src_b_i;
        iss.dst    = dst_i;
        iss.pc     = pc_i;
        iss.result = result_i;
        iss.fault  = fault_i;
    end

    spec_tag_regfile u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (res.wr_en),
        .wr_idx     (res.wr_idx),
        .wr_data    (res.wr_data),
        .wr_tag     (res.wr_tag),
        .ra_idx     (src_a_i),
        .rb_idx     (src_b_i),
        .rc_idx     (rd_idx_i),
        .ra_o       (opa),
        .rb_o       (opb),
        .rc_o       (opr),
        .tag_vec_o  (tag_vec),
        .data_vec_o (data_vec)
    );

    spec_tag_resolve u_resolve (
        .issue_valid (issue_valid_i),
        .iss         (iss),
        .opa         (opa),
        .opb         (opb),
        .out         (res)
    );

    spec_tag_report u_report (
        .clk            (clk),
        .rst            (rst),
        .rpt_en         (res.rpt_en),
        .rpt_pc         (res.rpt_pc),
        .rpt_deferred   (res.rpt_deferred),
        .exc_valid_o    (exc_valid_o),
        .exc_pc_o       (exc_pc_o),
        .exc_deferred_o (exc_deferred_o)
    );

    assign rd_data_o = opr.data;
    assign rd_tag_o  = opr.tag;

    // Speculative fault on clean sources defers its own counter.
    assert_spec_fault_defers_R3: assert property (@(posedge clk) disable iff (rst)
        (issue_valid_i && op_kind_i == 2'b00 && op_spec_i && fault_i &&
         !tag_vec[src_a_i] && !tag_vec[src_b_i])
        |=> tag_vec[$past(dst_i)] && data_vec[$past(dst_i)] == $past(pc_i));

    // Speculative consumer of poisoned source A carries its counter.
    assert_spec_carry_R4: assert property (@(posedge clk) disable iff (rst)
        (issue_valid_i && op_kind_i == 2'b00 && op_spec_i && tag_vec[src_a_i])
        |=> tag_vec[$past(dst_i)] && data_vec[$past(dst_i)] == $past(data_vec[src_a_i]));

    assert_own_fault_report_R5: assert property (@(posedge clk) disable iff (rst)
        (issue_valid_i && op_kind_i == 2'b00 && !op_spec_i && fault_i &&
         !tag_vec[src_a_i] && !tag_vec[src_b_i])
        |=> exc_valid_o && !exc_deferred_o && exc_pc_o == $past(pc_i));

    assert_deferred_report_R6: assert property (@(posedge clk) disable iff (rst)
        (issue_valid_i && op_kind_i == 2'b00 && !op_spec_i && tag_vec[src_a_i])
        |=> exc_valid_o && exc_deferred_o && exc_pc_o == $past(data_vec[src_a_i]));

    assert_no_write_on_report_R9: assert property (@(posedge clk) disable iff (rst)
        exc_valid_o |-> tag_vec == $past(tag_vec));

    assert_idle_holds_state_R11: assert property (@(posedge clk) disable iff (rst)
        !issue_valid_i |=> tag_vec == $past(tag_vec) && !exc_valid_o);

endmodule

// File: tb/spec_tag_tracker_tb_top.sv
`timescale 1ns/1ps
module spec_tag_tracker_tb_top;

    localparam int DW = 16;
    localparam int NR = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          issue_valid_i = 1'b0;
    logic [1:0]    op_kind_i = 2'b00;
    logic          op_spec_i = 1'b0;
    logic [2:0]    src_a_i = '0, src_b_i = '0, dst_i = '0, rd_idx_i = '0;
    logic [DW-1:0] pc_i = '0, result_i = '0;
    logic          fault_i = 1'b0;
    logic [DW-1:0] rd_data_o, exc_pc_o;
    logic          rd_tag_o, exc_valid_o, exc_deferred_o;

    int checks = 0;
    int errors = 0;

    // reference state
    int m_data [NR];
    bit m_tag  [NR];

    always #5 clk = ~clk;

    spec_tag_tracker dut_i (
        .clk(clk), .rst(rst), .issue_valid_i(issue_valid_i), .op_kind_i(op_kind_i),
        .op_spec_i(op_spec_i), .src_a_i(src_a_i), .src_b_i(src_b_i), .dst_i(dst_i),
        .pc_i(pc_i), .result_i(result_i), .fault_i(fault_i), .rd_idx_i(rd_idx_i),
        .rd_data_o(rd_data_o), .rd_tag_o(rd_tag_o), .exc_valid_o(exc_valid_o),
        .exc_pc_o(exc_pc_o), .exc_deferred_o(exc_deferred_o)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic sweep(string req);
        for (int i = 0; i < NR; i++) begin
            rd_idx_i = 3'(i);
            #0.4;
            chk(req, $sformatf("r%0d data", i), int'(rd_data_o), m_data[i]);
            chk(req, $sformatf("r%0d tag", i), int'(rd_tag_o), int'(m_tag[i]));
        end
    endtask

    // Drive one operation at a falling edge, model it, check one cycle later.
    task automatic run_op(string req, bit vld, int kind, bit spec, int a, int b, int d,
                          int pc, int res, bit flt);
        bit ev = 0, edf = 0;
        int epc = 0;
        int ca; bit ta, tb;
        ta = m_tag[a]; tb = m_tag[b];
        ca = ta ? m_data[a] : m_data[b];
        if (vld) begin
            if (kind == 0) begin
                if (spec) begin
                    if (ta || tb) begin m_tag[d] = 1; m_data[d] = ca; end
                    else if (flt) begin m_tag[d] = 1; m_data[d] = pc; end
                    else begin m_tag[d] = 0; m_data[d] = res; end
                end else begin
                    if (ta || tb) begin ev = 1; epc = ca; edf = 1; end
                    else if (flt) begin ev = 1; epc = pc; edf = 0; end
                    else begin m_tag[d] = 0; m_data[d] = res; end
                end
            end else if (kind == 1) begin
                if (ta) begin ev = 1; epc = m_data[a]; edf = 1; end
            end else if (kind == 2) begin
                m_tag[d] = flt; m_data[d] = res;
            end
        end
        issue_valid_i = vld; op_kind_i = 2'(kind); op_spec_i = spec;
        src_a_i = 3'(a); src_b_i = 3'(b); dst_i = 3'(d);
        pc_i = DW'(pc); result_i = DW'(res); fault_i = flt;
        @(negedge clk);
        issue_valid_i = 1'b0;
        chk(req, "exc_valid", int'(exc_valid_o), int'(ev));
        if (ev) begin
            chk(req, "exc_pc", int'(exc_pc_o), epc);
            chk(req, "exc_deferred", int'(exc_deferred_o), int'(edf));
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NR; i++) begin m_data[i] = 0; m_tag[i] = 0; end
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        chk("R1", "exc_valid after reset", int'(exc_valid_o), 0);
        sweep("R1");

        // R2 clean speculative write
        run_op("R2", 1, 0, 1, 0, 0, 1, 'h0010, 'h1111, 0); sweep("R2");
        // R3 speculative fault defers own counter
        run_op("R3", 1, 0, 1, 0, 1, 2, 'h0040, 'hdead, 1); sweep("R3");
        // R4 carry via source A, then via source B
        run_op("R4", 1, 0, 1, 2, 1, 3, 'h0044, 'h0099, 0); sweep("R4");
        run_op("R4", 1, 0, 1, 1, 3, 4, 'h0048, 'h0098, 1); sweep("R4");
        // R5 non-speculative own fault, no write
        run_op("R5", 1, 0, 0, 1, 1, 5, 'h0050, 'h5555, 1); sweep("R5");
        // R10 restore pairs
        run_op("R10", 1, 2, 0, 0, 0, 6, 'h0000, 'h0abc, 1);
        run_op("R10", 1, 2, 1, 0, 0, 7, 'h0000, 'h0077, 0); sweep("R10");
        // R6 / R8 / R9: back-to-back non-speculative consumers
        run_op("R6", 1, 0, 0, 3, 0, 0, 'h0060, 'h6666, 0);
        run_op("R8", 1, 0, 0, 6, 2, 0, 'h0064, 'h6767, 0);
        run_op("R8", 1, 0, 0, 2, 6, 0, 'h0068, 'h6868, 1);
        run_op("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0); sweep("R9");
        // R8 speculative carry with both poisoned
        run_op("R8", 1, 0, 1, 6, 2, 5, 'h0070, 'h7070, 0);
        run_op("R8", 1, 0, 1, 2, 6, 0, 'h0074, 'h7474, 0); sweep("R8");
        // R7 check: clean source, poisoned B only, poisoned A
        run_op("R7", 1, 1, 1, 1, 0, 3, 'h0080, 'h8888, 1);
        run_op("R7", 1, 1, 0, 7, 6, 3, 'h0084, 'h8484, 1);
        run_op("R7", 1, 1, 0, 4, 1, 1, 'h0088, 'h8080, 0); sweep("R7");
        // R11 invalid issue and no-op kind
        run_op("R11", 0, 0, 0, 6, 6, 1, 'h0090, 'h9999, 1);
        run_op("R11", 1, 3, 1, 6, 6, 1, 'h0094, 'h9494, 1); sweep("R11");
        // R2 overwrite poisoned register with clean result
        run_op("R2", 1, 0, 1, 7, 1, 2, 'h00a0, 'h2222, 0); sweep("R2");
        // R1 reset mid-run
        do_reset();
        chk("R1", "exc_valid after reset", int'(exc_valid_o), 0);
        sweep("R1");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule